// File: doc/BRIEF.md
# Programmable Mode-Select Frequency Divider

This block is a synchronous down counter that divides its clock by a programmed ratio n. The count state has three parts. A low-order stage has a modulus of 2, 4, 5, 8 or 10, set by a three-line mode select. Three cascaded decimal digits follow it, and a small high-order digit sits on top. A 16-bit jam word gives the starting value. The mode decides how the lowest four jam bits are split between the low-order stage and the high-order digit. When the count reaches its last state, every stage reloads from the jam word and the output gives one pulse.

A hold-enable input makes the output a latched timeout flag in most modes. One select pattern ignores the jam word and runs a fixed ratio of 10000. When both the second and the third select line are low, the counter is parked at its starting point, and counting resumes one edge after that condition ends. The block is used as the programmable divider in the feedback path of a frequency synthesizer, and also as a general timeout timer.

Top module: `modn_divider`

## Requirements
- R1: While `rst` is high at a clock edge, `q_out` is low after that edge. Reset leaves the counter parked, so the first edge after `rst` falls counts as the arming edge of R10.
- R2: Selects (`sel_a`,`sel_b`,`sel_c`) give the low-stage modulus M and the split of `jam[3:0]`. 111: M=2, low=`jam[0]`, high=`jam[3:1]`. 011: M=4, low=`jam[1:0]`, high=`jam[3:2]`. 101: M=5, low=`jam[2:0]`, high=`jam[3]`. 001: M=8, low=`jam[2:0]`, high=`jam[3]`. 110 and 010: M=10, low=`jam[3:0]`, no high digit. The ratio is n = M·(1000·high + 100·hundreds + 10·tens + units) + low, with n of 3 or more.
- R3: `jam[7:4]` gives the units digit, `jam[11:8]` the tens digit and `jam[15:12]` the hundreds digit. The least significant bit of each field is its lowest-numbered bit.
- R4: In steady counting, `q_out` rises once every n clocks. Without latching, each pulse lasts exactly one clock.
- R5: A decimal digit loaded with 10 to 15 still carries its place value in the formula of R2. For example, mode 001 with `jam`=16'hFFFF gives a period of 21327.
- R6: With `le` high in any counting mode except 010, `q_out` stays high from a terminal count until the first edge that samples `le` low, and it falls after that edge. Counting goes on while the output is held.
- R7: Mode 010 with `le` low reloads 10000 at each terminal count and ignores `jam`. The first cycle after leaving the parked state still uses `jam`.
- R8: Mode 010 with `le` high divides with M=10, using the split of R2, and never latches `q_out`.
- R9: While `sel_b`=`sel_c`=0, the counter is parked. `q_out` shows no rising edge, and a latched level clears after the first such edge unless `le` keeps it.
- R10: After the parked state ends, the first edge loads `jam` and the countdown begins on the next edge. The first rise of `q_out` therefore follows the (n+1)-th edge after exit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset into the parked state |
| jam | input | 16 | Starting value: low/high split in bits 3:0, then units, tens, hundreds |
| sel_a | input | 1 | Mode select line a |
| sel_b | input | 1 | Mode select line b |
| sel_c | input | 1 | Mode select line c |
| le | input | 1 | Hold enable for the latched timer output |
| q_out | output | 1 | Registered divided output |

## Verification
Every piece of internal state shows up as the time of a rising edge on `q_out`. A borrow that goes wrong, a digit that wraps to the wrong value or a field that is misallocated moves the first pulse after exit, or the pulse after it, by at least one clock. The bench compares every rise against the cycle computed from the ratio formula. A fault in the arming or hold logic shows up within n+1 clocks of leaving the parked state. A fault in the latch shows up as a wrong output level one edge after `le` changes.

// File: rtl/modn_pkg.sv
package modn_pkg;

  localparam int DIG_W = 4;          // width of the low stage and of each decimal digit
  localparam int TOP_W = DIG_W - 1;  // width of the high-order digit

  typedef enum logic [2:0] {
    DIV2  = 3'd0,
    DIV4  = 3'd1,
    DIV5  = 3'd2,
    DIV8  = 3'd3,
    DIV10 = 3'd4
  } div_mode_e;

  // Largest value of the low stage, reached when it wraps on a borrow
  function automatic logic [DIG_W-1:0] low_wrap(input div_mode_e m);
    case (m)
      DIV2:    low_wrap = 4'd1;
      DIV4:    low_wrap = 4'd3;
      DIV5:    low_wrap = 4'd4;
      DIV8:    low_wrap = 4'd7;
      default: low_wrap = 4'd9;
    endcase
  endfunction

endpackage

// File: rtl/modn_mode_dec.sv
module modn_mode_dec
  import modn_pkg::*;
(
  input  logic      sel_a,
  input  logic      sel_b,
  input  logic      sel_c,
  input  logic      le,
  output logic      parked,
  output div_mode_e mode,
  output logic      fixed_ratio,
  output logic      latch_en
);

  logic plain_ten;

  assign parked    = !sel_b && !sel_c;
  assign plain_ten = !sel_a && sel_b && !sel_c;

  always_comb begin
    case ({sel_a, sel_b, sel_c})
      3'b111:  mode = DIV2;
      3'b011:  mode = DIV4;
      3'b101:  mode = DIV5;
      3'b001:  mode = DIV8;
      default: mode = DIV10;
    endcase
  end

  assign fixed_ratio = plain_ten && !le;
  assign latch_en    = le && !plain_ten;

endmodule

// File: rtl/modn_load_map.sv
module modn_load_map
  import modn_pkg::*;
#(
  parameter int NUM_DEC = 3,
  localparam int JAM_W  = DIG_W * (NUM_DEC + 1)
) (
  input  logic [JAM_W-1:0]              jam,
  input  div_mode_e                     mode,
  input  logic                          use_fixed,
  output logic [DIG_W-1:0]              low_ld,
  output logic [NUM_DEC-1:0][DIG_W-1:0] dec_ld,
  output logic [TOP_W-1:0]              top_ld
);

  localparam logic [DIG_W-1:0] FIXED_MSD = DIG_W'(10);

  // Split of the lowest jam nibble between the low stage and the high digit
  always_comb begin
    low_ld = '0;
    top_ld = '0;
    if (!use_fixed) begin
      case (mode)
        DIV2: begin
          low_ld = {3'b000, jam[0]};
          top_ld = jam[3:1];
        end
        DIV4: begin
          low_ld = {2'b00, jam[1:0]};
          top_ld = {1'b0, jam[3:2]};
        end
        DIV5, DIV8: begin
          low_ld = {1'b0, jam[2:0]};
          top_ld = {2'b00, jam[3]};
        end
        default: begin
          low_ld = jam[3:0];
          top_ld = '0;
        end
      endcase
    end
  end

  // Decimal digits: straight jam fields, or the fixed 10000 pattern
  for (genvar i = 0; i < NUM_DEC; i++) begin : g_dec_ld
    if (i == NUM_DEC - 1) begin : g_msd
      assign dec_ld[i] = use_fixed ? FIXED_MSD : jam[DIG_W*(i+1) +: DIG_W];
    end else begin : g_lsd
      assign dec_ld[i] = use_fixed ? '0 : jam[DIG_W*(i+1) +: DIG_W];
    end
  end

endmodule

// File: rtl/modn_digit.sv
module modn_digit #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         step,
  input  logic [W-1:0] wrap_val,
  output logic [W-1:0] val
);

  always_ff @(posedge clk) begin
    if (rst) begin
      val <= '0;
    end else if (ld) begin
      val <= ld_val;
    end else if (step) begin
      val <= (val == '0) ? wrap_val : val - W'(1);
    end
  end

endmodule

// File: rtl/modn_divider.sv
module modn_divider
  import modn_pkg::*;
#(
  parameter int NUM_DEC = 3,
  localparam int JAM_W  = DIG_W * (NUM_DEC + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [JAM_W-1:0] jam,
  input  logic             sel_a,
  input  logic             sel_b,
  input  logic             sel_c,
  input  logic             le,
  output logic             q_out
);

  localparam logic [DIG_W-1:0] DEC_WRAP = DIG_W'(9);
  localparam logic [TOP_W-1:0] TOP_WRAP = '1;

  logic      parked, fixed_ratio, latch_en;
  div_mode_e mode;

  logic                          armed_q;
  logic                          q_q;
  logic [DIG_W-1:0]              low_ld, low_val;
  logic [NUM_DEC-1:0][DIG_W-1:0] dec_ld, dec_val;
  logic [TOP_W-1:0]              top_ld, top_val;
  logic [NUM_DEC:0]              step_v;
  logic [NUM_DEC-1:0]            dec_zero;
  logic                          terminal, counting, load_now;

  modn_mode_dec mode_dec_i (
    .sel_a       (sel_a),
    .sel_b       (sel_b),
    .sel_c       (sel_c),
    .le          (le),
    .parked      (parked),
    .mode        (mode),
    .fixed_ratio (fixed_ratio),
    .latch_en    (latch_en)
  );

  // The fixed ratio replaces the jam word only on a terminal reload, never on arming
  modn_load_map #(.NUM_DEC(NUM_DEC)) load_map_i (
    .jam       (jam),
    .mode      (mode),
    .use_fixed (fixed_ratio && armed_q),
    .low_ld    (low_ld),
    .dec_ld    (dec_ld),
    .top_ld    (top_ld)
  );

  assign counting = !parked && armed_q;
  assign load_now = !parked && (!armed_q || terminal);

  // Low-order stage steps on every counting edge that is not a reload
  assign step_v[0] = counting && !terminal;

  modn_digit #(.W(DIG_W)) low_i (
    .clk      (clk),
    .rst      (rst),
    .ld       (load_now),
    .ld_val   (low_ld),
    .step     (step_v[0]),
    .wrap_val (low_wrap(mode)),
    .val      (low_val)
  );

  // Borrow ripples upward through the decimal digits
  for (genvar i = 0; i < NUM_DEC; i++) begin : g_dec
    logic below_zero;
    if (i == 0) begin : g_first
      assign below_zero = (low_val == '0);
    end else begin : g_next
      assign below_zero = dec_zero[i-1];
    end
    assign step_v[i+1] = step_v[i] && below_zero;
    assign dec_zero[i] = (dec_val[i] == '0);

    modn_digit #(.W(DIG_W)) dec_i (
      .clk      (clk),
      .rst      (rst),
      .ld       (load_now),
      .ld_val   (dec_ld[i]),
      .step     (step_v[i+1]),
      .wrap_val (DEC_WRAP),
      .val      (dec_val[i])
    );
  end

  modn_digit #(.W(TOP_W)) top_i (
    .clk      (clk),
    .rst      (rst),
    .ld       (load_now),
    .ld_val   (top_ld),
    .step     (step_v[NUM_DEC] && dec_zero[NUM_DEC-1]),
    .wrap_val (TOP_WRAP),
    .val      (top_val)
  );

  // Last state of a cycle: composite value one
  assign terminal = (low_val == DIG_W'(1)) && (&dec_zero) && (top_val == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      q_q     <= 1'b0;
    end else begin
      armed_q <= !parked;
      q_q     <= (counting && terminal) || (q_q && latch_en);
    end
  end

  assign q_out = q_q;

endmodule

// File: rtl/modn_divider_chk.sv
module modn_divider_chk (
  input logic clk,
  input logic rst,
  input logic sel_a,
  input logic sel_b,
  input logic sel_c,
  input logic le,
  input logic q_out
);

  logic parked_now, was_parked, holds;

  assign parked_now = !sel_b && !sel_c;
  assign holds      = le && !(!sel_a && sel_b && !sel_c);

  always_ff @(posedge clk) begin
    if (rst) was_parked <= 1'b1;
    else     was_parked <= parked_now;
  end

  p_reset_clear_r1: assert property (@(posedge clk) rst |=> !q_out);

  p_parked_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    parked_now |=> !$rose(q_out));

  p_arm_edge_r10: assert property (@(posedge clk) disable iff (rst)
    (was_parked && !parked_now) |=> !$rose(q_out));

  p_single_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    (q_out && !holds) |=> !q_out);

  p_timer_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (q_out && holds) |=> q_out);

endmodule

bind modn_divider modn_divider_chk chk_i (
  .clk   (clk),
  .rst   (rst),
  .sel_a (sel_a),
  .sel_b (sel_b),
  .sel_c (sel_c),
  .le    (le),
  .q_out (q_out)
);

// File: tb/modn_divider_tb_top.sv
module modn_divider_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] jam = 16'h0025;
  logic        sel_a = 1'b1, sel_b = 1'b1, sel_c = 1'b0, le = 1'b0;
  logic        q_out;

  always #2 clk = ~clk;

  modn_divider dut_i (
    .clk   (clk),
    .rst   (rst),
    .jam   (jam),
    .sel_a (sel_a),
    .sel_b (sel_b),
    .sel_c (sel_c),
    .le    (le),
    .q_out (q_out)
  );

  int    cyc = 0;
  int    n_cmp = 0;
  int    n_bad = 0;
  int    exp_q[$];
  string tag_q[$];
  string cur_tag = "R1";
  bit    single_chk = 1'b0;
  logic  q_prev = 1'b0;
  bit    done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: every rising edge of q_out is popped from the scoreboard
  always @(negedge clk) begin
    int    e;
    string t;
    if (!rst) begin
      if (q_out && !q_prev) begin
        n_cmp++;
        if (exp_q.size() == 0) begin
          n_bad++;
          $display("FAIL %s: rise at cycle %0d, expected none", cur_tag, cyc);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (cyc != e) begin
            n_bad++;
            $display("FAIL %s: rise at cycle %0d, expected %0d", t, cyc, e);
          end
        end
      end
      if (single_chk && q_prev && q_out) begin
        n_cmp++;
        n_bad++;
        $display("FAIL R4: q_out high two cycles at %0d, actual 1 expected 0", cyc);
      end
    end
    q_prev = q_out;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp_v, cyc);
    end
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic park(input logic [15:0] j, input int edges);
    @(negedge clk);
    sel_b = 1'b0; sel_c = 1'b0; le = 1'b0; jam = j; single_chk = 1'b0;
    repeat (edges) @(negedge clk);
  endtask

  // Driver: park, exit into a mode, push the expected rise cycles (R10 timing)
  task automatic run_case(input logic a, input logic b, input logic c, input logic l,
                          input logic [15:0] j, input int n, input int nr,
                          input string tag, input bit single);
    int p;
    park(j, 3);
    chk(q_out == 1'b0, "R9", int'(q_out), 0);
    sel_a = a; sel_b = b; sel_c = c; le = l; cur_tag = tag; single_chk = single;
    p = cyc;
    for (int k = 0; k < nr; k++) begin
      exp_q.push_back(p + 1 + n + k * n);
      tag_q.push_back(tag);
    end
    wait_until(p + 1 + n * nr + 2);
    chk(exp_q.size() == 0, tag, exp_q.size(), 0);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int p;
    int e;

    // R1: reset holds q_out low; release leads straight into an arming edge
    repeat (3) @(negedge clk);
    chk(q_out == 1'b0, "R1", int'(q_out), 0);
    rst = 1'b0;
    p = cyc;
    cur_tag = "R1";
    exp_q.push_back(p + 26); tag_q.push_back("R1");
    exp_q.push_back(p + 51); tag_q.push_back("R4");
    single_chk = 1'b1;
    wait_until(p + 53);
    chk(exp_q.size() == 0, "R1", exp_q.size(), 0);

    // R9: long parked interval, no pulse, output low
    park(16'h0025, 40);
    cur_tag = "R9";
    chk(q_out == 1'b0, "R9", int'(q_out), 0);

    // R4: divide by 10 with a small n, single-cycle pulses
    run_case(1'b1, 1'b1, 1'b0, 1'b0, 16'h0025, 25, 3, "R4", 1'b1);
    // R2: divide-by-2 split, high digit worth 2000
    run_case(1'b1, 1'b1, 1'b1, 1'b0, 16'h0003, 2001, 2, "R2", 1'b1);
    // R2 / R3: divide-by-5 split, n = 8479
    run_case(1'b1, 1'b0, 1'b1, 1'b0, 16'h695C, 8479, 2, "R2", 1'b1);
    // R3: divide-by-10, decimal fields in place, n = 8479
    run_case(1'b1, 1'b1, 1'b0, 1'b0, 16'h8479, 8479, 2, "R3", 1'b1);
    // R8: mode 010 with le high, ratio 37 and no latching
    run_case(1'b0, 1'b1, 1'b0, 1'b1, 16'h0037, 37, 3, "R8", 1'b1);

    // R6: timer mode, divide-by-4, n = 7
    park(16'h0013, 3);
    sel_a = 1'b0; sel_b = 1'b1; sel_c = 1'b1; le = 1'b1; cur_tag = "R6";
    p = cyc;
    e = p + 8;
    exp_q.push_back(e);     tag_q.push_back("R6");
    exp_q.push_back(e + 7); tag_q.push_back("R6");
    wait_until(e + 1);
    chk(q_out == 1'b1, "R6", int'(q_out), 1);
    wait_until(e + 3);
    chk(q_out == 1'b1, "R6", int'(q_out), 1);
    le = 1'b0;
    @(negedge clk);
    chk(q_out == 1'b0, "R6", int'(q_out), 0);
    wait_until(e + 9);
    chk(exp_q.size() == 0, "R6", exp_q.size(), 0);

    // R10: park mid-count, restart takes n+1 edges from exit
    park(16'h0016, 3);
    sel_a = 1'b0; sel_b = 1'b0; sel_c = 1'b1; cur_tag = "R10";
    p = cyc;
    wait_until(p + 6);
    sel_b = 1'b0; sel_c = 1'b0;
    repeat (4) @(negedge clk);
    sel_c = 1'b1;
    p = cyc;
    exp_q.push_back(p + 15); tag_q.push_back("R10");
    wait_until(p + 14);
    chk(q_out == 1'b0, "R10", int'(q_out), 0);
    wait_until(p + 17);
    chk(exp_q.size() == 0, "R10", exp_q.size(), 0);

    // R7: fixed 10000 after a first cycle taken from jam (53)
    park(16'h0053, 3);
    sel_a = 1'b0; sel_b = 1'b1; sel_c = 1'b0; le = 1'b0; cur_tag = "R7";
    single_chk = 1'b1;
    p = cyc;
    exp_q.push_back(p + 54);         tag_q.push_back("R7");
    exp_q.push_back(p + 54 + 10000); tag_q.push_back("R7");
    wait_until(p + 54 + 10002);
    chk(exp_q.size() == 0, "R7", exp_q.size(), 0);

    // R5: digits loaded with 15, divide-by-8 maximum of 21327
    run_case(1'b0, 1'b0, 1'b1, 1'b0, 16'hFFFF, 21327, 2, "R5", 1'b1);

    park(16'h0000, 3);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule